// File: doc/BRIEF.md
# Four-Channel Pulse-Width Modulator

This block drives four pulse-width outputs from one functional clock. Software sets it up through a small register port. The port has a write strobe, a word address and write data, and a read-data bus that follows the address combinationally.

Four divider generators each count the clock down by a programmable 16-bit ratio. Each generator emits a one-cycle tick at the end of every ratio. Each channel picks one generator through a two-bit select field. The channel steps an 8-bit position counter on that generator's ticks. The output is high while the position is below the channel's 8-bit duty threshold. A full period is therefore 256 ticks long.

A per-channel bypass flag forces the output steadily high, which gives full duty. Register changes act at once: a write to a ratio or a duty register throws away the period in progress and starts over.

Each channel is a five-state machine. The states are:
- CH_OFF: output enable clear, output low.
- CH_FULL: enabled with bypass set, output high.
- CH_STALL: enabled, not bypassed, but the counter enable is clear or the selected ratio is zero; output low.
- CH_HIGH: running, position below the duty threshold; output high.
- CH_LOW: running, position at or above the duty threshold; output low.

The machine re-decides its state on every clock, and any state can move to any other. The transitions are tested in this priority order:
1. To CH_OFF when the enable is clear.
2. Otherwise to CH_FULL when bypass is set.
3. Otherwise to CH_STALL when stalled.
4. Otherwise to CH_HIGH or CH_LOW by comparing the position with the threshold.

The move from CH_HIGH to CH_LOW happens when the position reaches the threshold. The move from CH_LOW back to CH_HIGH happens when the position wraps to zero or a restart clears it.

Top module: `pwm_quad`

## Requirements
- R1: After reset every register reads zero and all four outputs are low.
- R2: Register map, by word address:
  - Address 0: output enables in bits [3:0] and bypass flags in bits [11:8].
  - Address 1: counter enables in bits [3:0].
  - Addresses 2+g: the 16-bit ratio of generator g in bits [15:0].
  - Addresses 6+n: the duty threshold of channel n in bits [7:0] and its generator select in bits [9:8].
  - Every register reads back the last value written. Unused bits and unmapped addresses read zero.
- R3: Generator g ticks once every RATIO_g clocks. A ratio of zero produces no ticks, and an enabled, unbypassed channel selecting it stays low.
- R4: A running channel repeats a period of 256×RATIO clocks. It is high for the first DUTY×RATIO clocks of each period and low for the rest.
- R5: The select field of channel n decides which generator's ticks advance its counter.
- R6: With its output enable clear, a channel's output is low whatever its bypass flag says.
- R7: With output enable and bypass both set, the output is constantly high.
- R8: With its counter enable clear, a channel's position holds at zero and its output stays low. Setting the counter enable again resumes normal operation.
- R9: A write to ratio register g clears generator g's count and the position of every channel selecting g. A write to channel n's duty register clears its position. Either way a fresh period starts.
- R10: Outputs are registered. A write captured at one rising edge shows on the outputs after the next rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Functional clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Word address for reads and writes |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| pwm_o | output | 4 | Pulse-width outputs, one per channel |

## Verification
The hardest situation to reach is a restart in the middle of a period. A ratio write must clear a generator's phase and the position of a channel that reaches it only through its select field. The result is visible only as the length of the following high pulse.

The stimulus sets up channel 1 on generator 2 with ratio 3 and duty 10. It lets the channel run, then rewrites generator 2 with the same ratio. After that write the output must stay high for exactly 30 cycles and then drop. The same write also checks that the other channels, which select other generators, are left alone.

// File: rtl/pwm_quad_pkg.sv
package pwm_quad_pkg;
    localparam int NUM_CH   = 4;
    localparam int RATIO_W  = 16;
    localparam int DUTY_W   = 8;
    localparam int DATA_W   = 32;
    localparam int ADDR_W   = 4;
    // word addresses; software decodes these positions
    localparam int A_CTRL   = 0;
    localparam int A_CNTEN  = 1;
    localparam int A_RATIO0 = 2;
    localparam int A_DUTY0  = A_RATIO0 + NUM_CH;
    localparam int BYP_LSB  = 8;

    typedef enum logic [2:0] {
        CH_OFF,
        CH_FULL,
        CH_STALL,
        CH_HIGH,
        CH_LOW
    } ch_state_e;
endpackage

// File: rtl/pwm_quad_regs.sv
module pwm_quad_regs
    import pwm_quad_pkg::*;
#(
    parameter int N_CH    = NUM_CH,
    parameter int R_W     = RATIO_W,
    parameter int D_W     = DUTY_W,
    parameter int AW      = ADDR_W,
    parameter int DW      = DATA_W,
    localparam int SEL_W  = $clog2(N_CH)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          we_i,
    input  logic [AW-1:0]                 addr_i,
    input  logic [DW-1:0]                 wdata_i,
    output logic [DW-1:0]                 rdata_o,
    output logic [N_CH-1:0]               out_en_o,
    output logic [N_CH-1:0]               bypass_o,
    output logic [N_CH-1:0]               cnt_en_o,
    output logic [N_CH-1:0][R_W-1:0]      ratio_o,
    output logic [N_CH-1:0][D_W-1:0]      duty_o,
    output logic [N_CH-1:0][SEL_W-1:0]    sel_o,
    output logic [N_CH-1:0]               ratio_wr_o,
    output logic [N_CH-1:0]               duty_wr_o
);
    localparam int DUTY_BASE = A_RATIO0 + N_CH;

    logic ctrl_wr;
    logic cnten_wr;

    assign ctrl_wr  = we_i && (addr_i == AW'(A_CTRL));
    assign cnten_wr = we_i && (addr_i == AW'(A_CNTEN));

    always_comb begin
        for (int i = 0; i < N_CH; i++) begin
            ratio_wr_o[i] = we_i && (addr_i == AW'(A_RATIO0 + i));
            duty_wr_o[i]  = we_i && (addr_i == AW'(DUTY_BASE + i));
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_en_o <= '0;
            bypass_o <= '0;
            cnt_en_o <= '0;
        end else begin
            if (ctrl_wr) begin
                out_en_o <= wdata_i[N_CH-1:0];
                bypass_o <= wdata_i[BYP_LSB +: N_CH];
            end
            if (cnten_wr) begin
                cnt_en_o <= wdata_i[N_CH-1:0];
            end
        end
    end

    for (genvar g = 0; g < N_CH; g++) begin : g_slot
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                ratio_o[g] <= '0;
                duty_o[g]  <= '0;
                sel_o[g]   <= '0;
            end else begin
                if (ratio_wr_o[g]) begin
                    ratio_o[g] <= wdata_i[R_W-1:0];
                end
                if (duty_wr_o[g]) begin
                    duty_o[g] <= wdata_i[D_W-1:0];
                    sel_o[g]  <= wdata_i[D_W +: SEL_W];
                end
            end
        end
    end

    always_comb begin
        rdata_o = '0;
        if (addr_i == AW'(A_CTRL)) begin
            rdata_o[N_CH-1:0]        = out_en_o;
            rdata_o[BYP_LSB +: N_CH] = bypass_o;
        end
        if (addr_i == AW'(A_CNTEN)) begin
            rdata_o[N_CH-1:0] = cnt_en_o;
        end
        for (int i = 0; i < N_CH; i++) begin
            if (addr_i == AW'(A_RATIO0 + i)) begin
                rdata_o[R_W-1:0] = ratio_o[i];
            end
            if (addr_i == AW'(DUTY_BASE + i)) begin
                rdata_o[D_W-1:0]     = duty_o[i];
                rdata_o[D_W +: SEL_W] = sel_o[i];
            end
        end
    end

    // R2
    reg_onehot_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ratio_wr_o, duty_wr_o, ctrl_wr, cnten_wr}));
endmodule

// File: rtl/pwm_quad_divgen.sv
module pwm_quad_divgen
    import pwm_quad_pkg::*;
#(
    parameter int R_W = RATIO_W
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [R_W-1:0] ratio_i,
    input  logic           restart_i,
    output logic           tick_o
);
    logic [R_W-1:0] phase_q;
    logic           at_end;

    assign at_end = (ratio_i != '0) && (phase_q >= ratio_i - R_W'(1));
    assign tick_o = at_end;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_q <= '0;
        end else if (restart_i || ratio_i == '0 || at_end) begin
            phase_q <= '0;
        end else begin
            phase_q <= phase_q + R_W'(1);
        end
    end

    // R3
    phase_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ratio_i != '0) |-> (phase_q < ratio_i));
    // R3
    tick_wraps_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> (phase_q == '0));
    // R9
    gen_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        restart_i |=> (phase_q == '0));
endmodule

// File: rtl/pwm_quad_chan.sv
module pwm_quad_chan
    import pwm_quad_pkg::*;
#(
    parameter int D_W = DUTY_W
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           out_en_i,
    input  logic           bypass_i,
    input  logic           cnt_en_i,
    input  logic           ratio_zero_i,
    input  logic           tick_i,
    input  logic           restart_i,
    input  logic [D_W-1:0] duty_i,
    output logic           pwm_o
);
    ch_state_e      state_q;
    ch_state_e      state_d;
    logic [D_W-1:0] pos_q;
    logic           stalled;
    logic           below;

    assign stalled = !cnt_en_i || ratio_zero_i;
    assign below   = pos_q < duty_i;

    // position counter: clears on stall or restart, steps on a tick
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pos_q <= '0;
        end else if (!cnt_en_i || restart_i) begin
            pos_q <= '0;
        end else if (tick_i) begin
            pos_q <= pos_q + D_W'(1);
        end
    end

    // next-state selection by priority
    always_comb begin
        state_d = CH_OFF;
        unique case (1'b1)
            !out_en_i:                                     state_d = CH_OFF;
            out_en_i && bypass_i:                          state_d = CH_FULL;
            out_en_i && !bypass_i && stalled:              state_d = CH_STALL;
            out_en_i && !bypass_i && !stalled && below:    state_d = CH_HIGH;
            out_en_i && !bypass_i && !stalled && !below:   state_d = CH_LOW;
            default:                                       state_d = CH_OFF;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= CH_OFF;
        end else begin
            state_q <= state_d;
        end
    end

    // output decode
    always_comb begin
        pwm_o = 1'b0;
        unique case (state_q)
            CH_FULL, CH_HIGH:         pwm_o = 1'b1;
            CH_OFF, CH_STALL, CH_LOW: pwm_o = 1'b0;
            default:                  pwm_o = 1'b0;
        endcase
    end

    // R6
    off_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !out_en_i |=> !pwm_o);
    // R7
    bypass_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_en_i && bypass_i) |=> pwm_o);
    // R8
    hold_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cnt_en_i |=> (pos_q == '0));
    // R9
    chan_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        restart_i |=> (pos_q == '0));
    // R4
    step_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_en_i && !restart_i && tick_i) |=> (pos_q == D_W'($past(pos_q) + 1'b1)));
    // R3
    stall_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_en_i && !bypass_i && ratio_zero_i) |=> !pwm_o);
endmodule

// File: rtl/pwm_quad.sv
module pwm_quad
    import pwm_quad_pkg::*;
#(
    parameter int N_CH = NUM_CH,
    parameter int R_W  = RATIO_W,
    parameter int D_W  = DUTY_W,
    parameter int AW   = ADDR_W,
    parameter int DW   = DATA_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            reg_we,
    input  logic [AW-1:0]   reg_addr,
    input  logic [DW-1:0]   reg_wdata,
    output logic [DW-1:0]   reg_rdata,
    output logic [N_CH-1:0] pwm_o
);
    localparam int SEL_W = $clog2(N_CH);

    logic [N_CH-1:0]            out_en;
    logic [N_CH-1:0]            bypass;
    logic [N_CH-1:0]            cnt_en;
    logic [N_CH-1:0][R_W-1:0]   ratio;
    logic [N_CH-1:0][D_W-1:0]   duty;
    logic [N_CH-1:0][SEL_W-1:0] sel;
    logic [N_CH-1:0]            ratio_wr;
    logic [N_CH-1:0]            duty_wr;
    logic [N_CH-1:0]            tick;

    pwm_quad_regs #(
        .N_CH (N_CH),
        .R_W  (R_W),
        .D_W  (D_W),
        .AW   (AW),
        .DW   (DW)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .we_i       (reg_we),
        .addr_i     (reg_addr),
        .wdata_i    (reg_wdata),
        .rdata_o    (reg_rdata),
        .out_en_o   (out_en),
        .bypass_o   (bypass),
        .cnt_en_o   (cnt_en),
        .ratio_o    (ratio),
        .duty_o     (duty),
        .sel_o      (sel),
        .ratio_wr_o (ratio_wr),
        .duty_wr_o  (duty_wr)
    );

    for (genvar g = 0; g < N_CH; g++) begin : g_gen
        pwm_quad_divgen #(
            .R_W (R_W)
        ) u_divgen (
            .clk       (clk),
            .rst_n     (rst_n),
            .ratio_i   (ratio[g]),
            .restart_i (ratio_wr[g]),
            .tick_o    (tick[g])
        );
    end

    for (genvar n = 0; n < N_CH; n++) begin : g_ch
        logic ch_restart;
        logic ch_ratio_zero;

        assign ch_restart    = duty_wr[n] || ratio_wr[sel[n]];
        assign ch_ratio_zero = (ratio[sel[n]] == '0);

        pwm_quad_chan #(
            .D_W (D_W)
        ) u_chan (
            .clk          (clk),
            .rst_n        (rst_n),
            .out_en_i     (out_en[n]),
            .bypass_i     (bypass[n]),
            .cnt_en_i     (cnt_en[n]),
            .ratio_zero_i (ch_ratio_zero),
            .tick_i       (tick[sel[n]]),
            .restart_i    (ch_restart),
            .duty_i       (duty[n]),
            .pwm_o        (pwm_o[n])
        );
    end
endmodule

// File: tb/test_pwm_quad.sv
module test_pwm_quad;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [3:0]  pwm_o;

    int compared = 0;
    int mismatched = 0;
    int cycles = 0;
    bit done = 1'b0;

    // behavioural reference state
    int m_en[4], m_byp[4], m_cen[4], m_div[4], m_duty[4], m_sel[4];
    int m_pc[4], m_tc[4], m_code[4];
    bit m_out[4], m_tick[4];

    pwm_quad i_pwm_quad (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .pwm_o     (pwm_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < 4; i++) begin
                m_en[i] = 0; m_byp[i] = 0; m_cen[i] = 0; m_div[i] = 0;
                m_duty[i] = 0; m_sel[i] = 0; m_pc[i] = 0; m_tc[i] = 0;
                m_out[i] = 0; m_code[i] = 0; m_tick[i] = 0;
            end
        end else begin
            int wa;
            bit w;
            int wd;
            w  = reg_we;
            wa = int'(reg_addr);
            wd = int'(reg_wdata);
            for (int n = 0; n < 4; n++) begin
                if (m_en[n] == 0) begin
                    m_out[n] = 0; m_code[n] = 0;
                end else if (m_byp[n] != 0) begin
                    m_out[n] = 1; m_code[n] = 1;
                end else if (m_cen[n] == 0 || m_div[m_sel[n]] == 0) begin
                    m_out[n] = 0; m_code[n] = 2;
                end else begin
                    m_out[n] = (m_tc[n] < m_duty[n]); m_code[n] = 3;
                end
            end
            for (int g = 0; g < 4; g++)
                m_tick[g] = (m_div[g] != 0) && (m_pc[g] >= m_div[g] - 1);
            for (int n = 0; n < 4; n++) begin
                bit rs;
                rs = w && (wa == 6 + n || wa == 2 + m_sel[n]);
                if (m_cen[n] == 0 || rs) m_tc[n] = 0;
                else if (m_tick[m_sel[n]]) m_tc[n] = (m_tc[n] + 1) % 256;
            end
            for (int g = 0; g < 4; g++) begin
                if ((w && wa == 2 + g) || m_div[g] == 0 || m_tick[g]) m_pc[g] = 0;
                else m_pc[g] = m_pc[g] + 1;
            end
            if (w) begin
                if (wa == 0) begin
                    for (int n = 0; n < 4; n++) begin
                        m_en[n] = (wd >> n) & 1;
                        m_byp[n] = (wd >> (8 + n)) & 1;
                    end
                end else if (wa == 1) begin
                    for (int n = 0; n < 4; n++) m_cen[n] = (wd >> n) & 1;
                end else if (wa >= 2 && wa <= 5) begin
                    m_div[wa-2] = wd & 16'hFFFF;
                end else if (wa >= 6 && wa <= 9) begin
                    m_duty[wa-6] = wd & 8'hFF;
                    m_sel[wa-6] = (wd >> 8) & 3;
                end
            end
        end
    end

    // cycle-by-cycle comparison against the reference
    always @(negedge clk) begin
        if (rst_n && !done) begin
            logic [3:0] exp_v;
            for (int n = 0; n < 4; n++) exp_v[n] = m_out[n];
            compared++;
            if (pwm_o !== exp_v) begin
                mismatched++;
                for (int n = 0; n < 4; n++) begin
                    if (pwm_o[n] !== exp_v[n]) begin
                        case (m_code[n])
                            0: $display("FAIL R6 ch%0d: actual %b expected %b", n, pwm_o[n], exp_v[n]);
                            1: $display("FAIL R7 ch%0d: actual %b expected %b", n, pwm_o[n], exp_v[n]);
                            2: $display("FAIL R8/R3 ch%0d: actual %b expected %b", n, pwm_o[n], exp_v[n]);
                            default: $display("FAIL R4 ch%0d: actual %b expected %b", n, pwm_o[n], exp_v[n]);
                        endcase
                    end
                end
            end
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG && !done) begin
            done = 1'b1;
            mismatched++;
            $display("FAIL watchdog (all requirements): actual %0d cycles expected below %0d", cycles, WATCHDOG);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp_v);
        compared++;
        if (!ok) begin
            mismatched++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp_v);
        end
    endtask

    task automatic wr(input int a, input int d);
        @(negedge clk);
        reg_we = 1'b1;
        reg_addr = 4'(a);
        reg_wdata = 32'(d);
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input int a, output int d);
        @(negedge clk);
        reg_addr = 4'(a);
        #1;
        d = int'(reg_rdata);
    endtask

    task automatic count_high(input int ch, input int len, output int c);
        c = 0;
        for (int k = 0; k < len; k++) begin
            @(negedge clk);
            c += int'(pwm_o[ch]);
        end
    endtask

    initial begin
        int v;
        int c;
        int acc;
        repeat (5) @(negedge clk);
        check(pwm_o == 4'b0, "R1 outputs in reset", int'(pwm_o), 0);
        rst_n = 1'b1;
        acc = 0;
        for (int a = 0; a < 10; a++) begin
            rd(a, v);
            acc |= v;
        end
        check(acc == 0, "R1 registers after reset", acc, 0);

        // R2 readback with unused bits masked
        wr(0, 32'hFFFF_FFFF); rd(0, v); check(v == 32'h0F0F, "R2 control", v, 32'h0F0F);
        wr(1, 32'hFFFF_FFFF); rd(1, v); check(v == 32'hF, "R2 counter enables", v, 32'hF);
        wr(3, 32'h0001_2345); rd(3, v); check(v == 32'h2345, "R2 ratio", v, 32'h2345);
        wr(8, 32'h0000_FFFF); rd(8, v); check(v == 32'h3FF, "R2 duty/select", v, 32'h3FF);
        rd(15, v); check(v == 0, "R2 unmapped", v, 0);
        wr(0, 0); wr(1, 0); wr(3, 0); wr(8, 0);

        // R4 channel 0 on generator 0, ratio 1, duty 64
        wr(2, 1); wr(6, 32'h040); wr(1, 32'hF); wr(0, 32'h1);
        repeat (300) @(negedge clk);
        count_high(0, 256, c); check(c == 64, "R4 high time ratio 1", c, 64);

        // R5 channel 1 selects generator 2, ratio 3, duty 10
        wr(4, 3); wr(7, 32'h20A); wr(0, 32'h3);
        repeat (100) @(negedge clk);
        count_high(1, 768, c); check(c == 30, "R5 selected generator", c, 30);

        // R9 rewrite generator 2 ratio: fresh period of 30 high clocks
        wr(4, 3);
        count_high(1, 30, c); check(c == 30, "R9 restart high run", c, 30);
        @(negedge clk); check(pwm_o[1] == 1'b0, "R9 restart falls", int'(pwm_o[1]), 0);

        // R3 zero ratio on generator 3 keeps channel 2 low
        wr(8, 32'h3C8); wr(0, 32'h7);
        count_high(2, 300, c); check(c == 0, "R3 zero ratio", c, 0);
        wr(5, 2);
        repeat (10) @(negedge clk);
        count_high(2, 512, c); check(c == 400, "R3 ratio 2 high time", c, 400);

        // R10 and R7 bypass on channel 3
        wr(9, 0); wr(0, 32'hF);
        repeat (5) @(negedge clk);
        wr(0, 32'h80F);
        check(pwm_o[3] == 1'b0, "R10 not yet visible", int'(pwm_o[3]), 0);
        @(negedge clk);
        check(pwm_o[3] == 1'b1, "R10 visible next edge", int'(pwm_o[3]), 1);
        count_high(3, 100, c); check(c == 100, "R7 bypass high", c, 100);

        // R6 enable clear beats bypass
        wr(0, 32'h806);
        @(negedge clk);
        count_high(3, 100, c); check(c == 0, "R6 disabled bypassed channel", c, 0);
        count_high(0, 100, c); check(c == 0, "R6 disabled channel 0", c, 0);

        // R8 counter enable clear stalls channel 0
        wr(0, 32'h1); wr(1, 32'hE);
        @(negedge clk);
        count_high(0, 300, c); check(c == 0, "R8 stalled", c, 0);
        wr(1, 32'hF);
        repeat (10) @(negedge clk);
        count_high(0, 256, c); check(c == 64, "R8 resumed", c, 64);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule